// File: doc/BRIEF.md
# Chainable Serial Result Port

This block is the digital serial output side of a sampling converter. Identical ports can be wired in a chain. Each port's data output feeds the data input of the next one. All ports share one start line and one shift clock. The first port in the chain has its data input tied low.

A rising edge on the start line does three things at once. It fixes the operating mode from the chain input level, it records whether a busy indicator was requested, and it starts a conversion. A timer stands in for the conversion engine and runs for a fixed number of system clock cycles. When the timer expires, the port captures the 16-bit result presented on its result bus and drives that result's most significant bit straight away. Each later falling edge of the shift clock moves the register one place toward the output. The vacated bit at the bottom of the register is filled from the chain input. After sixteen edges the port simply forwards its neighbour's data, so the host reads the last device's word first.

All three serial inputs come from another clock domain. They are synchronised to the system clock, and their edges are detected in that domain. A falling edge on the start line ends the frame. If that edge arrives during a conversion, the conversion is abandoned.

Top module: `chain_port`

## Requirements
- R1: After reset, `sdo_o`, `chain_mode_o` and `busy_req_o` are all 0.
- R2: `sdo_o` is 0 whenever no readout is in progress, including the time when `cnv_i` and `sdi_i` are both low before a frame.
- R3: At a rising edge of `cnv_i`, `chain_mode_o` is set to 1 if `sdi_i` is low and to 0 if `sdi_i` is high. It holds that value until the next rising edge.
- R4: At a rising edge of `cnv_i`, `busy_req_o` takes the level of `sclk_i` (1 means a busy indicator was requested).
- R5: A conversion lasts exactly `CONV_CYCLES` system clock cycles. Falling edges of `sclk_i` during the conversion neither shorten it nor shift data, and `sdo_o` stays 0 until it ends.
- R6: When the conversion ends, the port captures `result_i` and `sdo_o` shows `result_i[15]` before any falling edge of `sclk_i`. Later changes to `result_i` have no effect on that frame.
- R7: Each falling edge of `sclk_i` during readout moves the next lower result bit onto `sdo_o`, most significant bit first.
- R8: At each falling edge, the level of `sdi_i` enters the bottom of the register. From the 16th falling edge on, `sdo_o` repeats the `sdi_i` bits in the order they were taken.
- R9: A falling edge of `cnv_i` during readout drives `sdo_o` to 0. Further `sclk_i` edges leave it at 0 until a new frame starts.
- R10: A falling edge of `cnv_i` during a conversion abandons it. No result is loaded, and `sdo_o` stays 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Start line: rising edge starts a frame, falling edge ends it |
| sclk_i | input | 1 | Shift clock; data moves on its falling edge |
| sdi_i | input | 1 | Chain input from the upstream port (tie low on the first port) |
| result_i | input | 16 | Conversion result, captured when the conversion ends |
| sdo_o | output | 1 | Serial data out to the downstream port or the host |
| chain_mode_o | output | 1 | 1 when the last frame started in chain mode |
| busy_req_o | output | 1 | 1 when the shift clock was high at the last frame start |

## Verification
A stale or corrupted shift register shows up on `sdo_o` within a few system clocks of the next shift-clock falling edge. That is where the bench compares every bit of a frame, including the forwarded chain bits, against a software shift model. A state machine that stays in readout after the start line falls is exposed by `sdo_o` staying high when it should be low. A timer with the wrong length shows as a most significant bit that appears early, or is missing, at the point where the conversion should end. Mode and busy flags that are captured wrongly are visible on their own outputs a handful of cycles after the start edge.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } port_state_e;
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cp_conv_timer.sv
module cp_conv_timer #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= LOAD_VAL;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (abort_i || cnt_q == '0) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0) && !abort_i;
endmodule

// File: rtl/cp_shift_reg.sv
module cp_shift_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             shift_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= load_data_i;
    else if (shift_i) sreg_q <= {sreg_q[WIDTH-2:0], ser_i};
  end

  assign q_o = sreg_q;
endmodule

// File: rtl/chain_port.sv
module chain_port
  import chain_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              chain_mode_o,
  output logic              busy_req_o
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] raw_in, sync_out;
  logic cnv_s, sclk_s, sdi_s;
  logic cnv_q, sclk_q;
  logic cnv_rise, cnv_fall, sclk_fall;
  logic conv_start, conv_busy, conv_done;
  logic shift_en;
  logic [DATA_W-1:0] shift_q;
  port_state_e state_q, state_d;
  logic mode_q, busy_req_q;

  assign raw_in = {sdi_i, sclk_i, cnv_i};

  cp_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign cnv_s  = sync_out[0];
  assign sclk_s = sync_out[1];
  assign sdi_s  = sync_out[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cnv_q  <= cnv_s;
      sclk_q <= sclk_s;
    end
  end

  assign cnv_rise  = cnv_s && !cnv_q;
  assign cnv_fall  = !cnv_s && cnv_q;
  assign sclk_fall = !sclk_s && sclk_q;

  assign conv_start = (state_q == ST_IDLE) && cnv_rise;

  cp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(conv_start),
    .abort_i(cnv_fall),
    .busy_o (conv_busy),
    .done_o (conv_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cnv_rise) state_d = ST_CONV;
      ST_CONV: begin
        if (cnv_fall)       state_d = ST_IDLE;
        else if (conv_done) state_d = ST_READ;
      end
      ST_READ: if (cnv_fall) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      busy_req_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (conv_start) begin
        mode_q     <= !sdi_s;
        busy_req_q <= sclk_s;
      end
    end
  end

  assign shift_en = (state_q == ST_READ) && sclk_fall && !cnv_fall;

  cp_shift_reg #(.WIDTH(DATA_W)) u_sreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (conv_done && (state_q == ST_CONV)),
    .load_data_i(result_i),
    .shift_i    (shift_en),
    .ser_i      (sdi_s),
    .q_o        (shift_q)
  );

  // output is forced low outside readout
  assign sdo_o        = (state_q == ST_READ) && shift_q[DATA_W-1];
  assign chain_mode_o = mode_q;
  assign busy_req_o   = busy_req_q;

  logic unused_busy;
  assign unused_busy = conv_busy;
endmodule

// File: rtl/chain_port_chk.sv
module chain_port_chk
  import chain_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input port_state_e       state_q,
  input logic              sclk_s,
  input logic              sdi_s,
  input logic              cnv_fall,
  input logic              sclk_fall,
  input logic              conv_start,
  input logic              conv_done,
  input logic [DATA_W-1:0] result_i,
  input logic [DATA_W-1:0] shift_q,
  input logic              sdo_o,
  input logic              chain_mode_o,
  input logic              busy_req_o
);
  int unsigned conv_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 conv_cnt_q <= 0;
    else if (state_q != ST_CONV) conv_cnt_q <= 0;
    else                         conv_cnt_q <= conv_cnt_q + 1;
  end

  // R3
  mode_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start |=> chain_mode_o == !$past(sdi_s));

  // R4
  busy_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start |=> busy_req_o == $past(sclk_s));

  // R5
  conv_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done && state_q == ST_CONV) |-> conv_cnt_q == CONV_CYCLES - 1);

  // R6
  load_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done && state_q == ST_CONV) |=> sdo_o == $past(result_i[DATA_W-1]));

  // R7
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && sclk_fall && !cnv_fall) |=> sdo_o == $past(shift_q[DATA_W-2]));

  // R9
  read_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && cnv_fall) |=> !sdo_o);

  // R10
  conv_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && cnv_fall) |=> (state_q == ST_IDLE && !sdo_o));
endmodule

bind chain_port chain_port_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_q     (state_q),
  .sclk_s      (sclk_s),
  .sdi_s       (sdi_s),
  .cnv_fall    (cnv_fall),
  .sclk_fall   (sclk_fall),
  .conv_start  (conv_start),
  .conv_done   (conv_done),
  .result_i    (result_i),
  .shift_q     (shift_q),
  .sdo_o       (sdo_o),
  .chain_mode_o(chain_mode_o),
  .busy_req_o  (busy_req_o)
);

// File: tb/chain_port_bench.sv
module chain_port_bench;
  localparam int CONV = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cnv = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] result = '0;
  logic sdo, mode, breq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chain_port #(.CONV_CYCLES(CONV)) u_chain_port (
    .clk_i(clk), .rst_ni(rst_ni), .cnv_i(cnv), .sclk_i(sclk), .sdi_i(sdi),
    .result_i(result), .sdo_o(sdo), .chain_mode_o(mode), .busy_req_o(breq)
  );

  function automatic logic [15:0] model_shift(logic [15:0] r, logic b);
    return {r[14:0], b};
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse(logic bitv);
    sdi = bitv;
    sclk = 1'b1; clks(3);
    sclk = 1'b0; clks(5);
  endtask

  // full frame: start, conversion, 32 falling edges, end
  task automatic frame(logic [15:0] res, logic [15:0] up, logic din0, logic sclk0);
    logic [15:0] m;
    result = res;
    sdi = din0; sclk = sclk0; clks(4);
    cnv = 1'b1; clks(4);
    check("R3", mode, !din0);
    check("R4", breq, sclk0);
    sclk = 1'b0; sdi = 1'b0;
    // R5: shift clock activity during conversion is ignored
    sclk_pulse(1'b1);
    check("R5", sdo, 1'b0);
    clks(CONV);
    check("R6", sdo, res[15]);
    result = ~res;  // R6: no effect after capture
    m = res;
    for (int i = 0; i < 32; i++) begin
      logic b;
      b = (i < 16) ? up[15-i] : 1'b0;
      sclk_pulse(b);
      m = model_shift(m, b);
      if (i < 15) check("R7", sdo, m[15]);
      else        check("R8", sdo, m[15]);
    end
    cnv = 1'b0; clks(4);
    check("R9", sdo, 1'b0);
    sclk_pulse(1'b1);
    check("R9", sdo, 1'b0);
    sdi = 1'b0; clks(2);
  endtask

  initial begin
    clks(3);
    check("R1", sdo, 1'b0);
    check("R1", mode, 1'b0);
    check("R1", breq, 1'b0);
    rst_ni = 1'b1;
    clks(4);
    check("R2", sdo, 1'b0);

    frame(16'hA5C3, 16'h1234, 1'b0, 1'b0);
    frame(16'h8001, 16'hFFFF, 1'b1, 1'b0);
    frame(16'h7FFE, 16'h0000, 1'b0, 1'b1);

    // R5: exact conversion length observed at the port
    result = 16'hFFFF; sdi = 1'b0; sclk = 1'b0; clks(3);
    cnv = 1'b1; clks(2 + CONV - 1);
    check("R5", sdo, 1'b0);
    clks(2);
    check("R5", sdo, 1'b1);
    cnv = 1'b0; clks(5);

    // R10: abort during conversion
    result = 16'hFFFF; cnv = 1'b1; clks(8);
    cnv = 1'b0; clks(CONV + 10);
    check("R10", sdo, 1'b0);
    sclk_pulse(1'b1);
    check("R10", sdo, 1'b0);
    check("R2", sdo, 1'b0);
    sdi = 1'b0; clks(4);

    void'($urandom(32'd77));
    for (int k = 0; k < 6; k++) begin
      logic [15:0] r, u;
      logic d0, s0;
      r = 16'($urandom); u = 16'($urandom);
      d0 = 1'($urandom); s0 = 1'($urandom);
      frame(r, u, d0, s0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule